// File: doc/BRIEF.md
# Functional-Unit Scoreboard Controller

This block tracks hazards for an out-of-order completion pipeline with five functional units: one integer/memory unit, one FP adder, two FP multipliers and one FP divider. Each cycle it is offered at most one decoded instruction, made of a unit kind, a destination register and two source registers. It decides whether that instruction may issue and to which unit. It tells each unit when its operands may be read, and it decides which finished unit may write its result back.

The controller holds no data. Each unit entry keeps its stage, its three register numbers, the tags of the units that will produce its sources, and a per-source ready flag. A register table records which unit will write each register. Structural, RAW, WAR and WAW hazards are all resolved from these tables. The register file, the datapath and the execution latency are outside the block. Each unit reports the end of its execution on its own done line.

Top module: `fu_scoreboard`

## Requirements
- R1: After reset no unit is busy: all grant outputs are low, and the first offered instruction is granted at once.
- R2: Kind encoding is 0 = integer/memory (unit 0), 1 = FP add (unit 1), 2 = FP multiply (unit 2, or unit 3 when unit 2 is busy), 3 = FP divide (unit 4). An instruction is not granted while every unit of its kind is busy.
- R3: An instruction is not granted while a unit that has not yet written back has the same destination register (WAW), even when its own unit is free.
- R4: A refused instruction stays at the head and is offered again. Nothing issues until it is granted.
- R5: A unit whose source register is still to be written by another unit does not read operands before the cycle after that unit's write grant (RAW).
- R6: A unit with no pending sources pulses its read-operands signal for exactly one cycle, in the cycle after its issue.
- R7: Execution done is accepted only after operands were read. The write grant comes at the earliest in the cycle after done is accepted.
- R8: A unit's write grant is held back while any other unit has the destination register as a source that is ready but not yet read (WAR).
- R9: At most one write grant is given per cycle. Among eligible units the lowest unit number wins.
- R10: A write grant frees the unit and its register entry, so a new instruction to that unit or that destination can be granted in the next cycle.
- R11: An instruction issued in the same cycle that its source's producer is granted write-back reads operands in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | Head instruction is present |
| iss_kind_i | input | 2 | Unit kind of the head instruction (R2 encoding) |
| iss_dst_i | input | RA | Destination register |
| iss_src1_i | input | RA | First source register |
| iss_src2_i | input | RA | Second source register |
| iss_grant_o | output | 1 | Head instruction issues this cycle |
| iss_fu_o | output | 3 | Unit number the instruction issues to |
| rd_go_o | output | 5 | Per-unit read-operands strobe |
| ex_done_i | input | 5 | Per-unit execution finished |
| wr_go_o | output | 5 | Per-unit write-back grant, one-hot or zero |

## Verification
Assertions check on every cycle that write grants are one-hot or zero and only go to units that finished execution. They also check that no unit is issued to while busy, that a register entry is never claimed twice, and that no write is granted in a cycle where another unit reads the same register. Only the directed scenarios can show the exact latencies: the read one cycle after issue, the RAW wait up to the producer's write, the WAR hold on a waiting reader, the same-cycle forwarding on issue, and the choice of the second multiplier when the first is busy.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_FU = 5;
  localparam int FU_W   = 3;

  typedef enum logic [1:0] {
    K_INT = 2'd0,
    K_ADD = 2'd1,
    K_MUL = 2'd2,
    K_DIV = 2'd3
  } fu_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EXEC,
    ST_WRITE
  } fu_stage_e;
endpackage

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
  import sb_pkg::*;
(
  input  logic              valid_i,
  input  fu_kind_e          kind_i,
  input  logic [NUM_FU-1:0] busy_i,
  input  logic              dst_pend_i,
  output logic              grant_o,
  output logic [FU_W-1:0]   fu_o,
  output logic [NUM_FU-1:0] fu_en_o
);
  always_comb begin
    unique case (kind_i)
      K_INT:   fu_o = FU_W'(0);
      K_ADD:   fu_o = FU_W'(1);
      K_MUL:   fu_o = busy_i[2] ? FU_W'(3) : FU_W'(2);
      default: fu_o = FU_W'(4);
    endcase
  end

  assign grant_o = valid_i && !busy_i[fu_o] && !dst_pend_i;

  always_comb begin
    fu_en_o = '0;
    fu_en_o[fu_o] = grant_o;
  end
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status
  import sb_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int RA = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_en_i,
  input  logic [RA-1:0]   set_idx_i,
  input  logic [FU_W-1:0] set_tag_i,
  input  logic            clr_en_i,
  input  logic [RA-1:0]   clr_idx_i,
  input  logic [FU_W-1:0] clr_tag_i,
  input  logic [RA-1:0]   rd_a_i,
  input  logic [RA-1:0]   rd_b_i,
  input  logic [RA-1:0]   rd_d_i,
  output logic            a_pend_o,
  output logic [FU_W-1:0] a_tag_o,
  output logic            b_pend_o,
  output logic [FU_W-1:0] b_tag_o,
  output logic            d_pend_o
);
  logic [NREGS-1:0] pend_q;
  logic [FU_W-1:0]  tag_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      for (int i = 0; i < NREGS; i++) tag_q[i] <= '0;
    end else begin
      if (clr_en_i) pend_q[clr_idx_i] <= 1'b0;
      if (set_en_i) begin
        pend_q[set_idx_i] <= 1'b1;
        tag_q[set_idx_i]  <= set_tag_i;
      end
    end
  end

  assign a_pend_o = pend_q[rd_a_i];
  assign a_tag_o  = tag_q[rd_a_i];
  assign b_pend_o = pend_q[rd_b_i];
  assign b_tag_o  = tag_q[rd_b_i];
  assign d_pend_o = pend_q[rd_d_i];

  p_claim_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> !pend_q[set_idx_i]);
  p_release_owner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |-> (pend_q[clr_idx_i] && tag_q[clr_idx_i] == clr_tag_i));
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int RA = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            iss_en_i,
  input  logic [RA-1:0]   dst_i,
  input  logic [RA-1:0]   src1_i,
  input  logic [RA-1:0]   src2_i,
  input  logic            q1_pend_i,
  input  logic [FU_W-1:0] q1_tag_i,
  input  logic            q2_pend_i,
  input  logic [FU_W-1:0] q2_tag_i,
  input  logic            wb_en_i,
  input  logic [FU_W-1:0] wb_tag_i,
  input  logic            ex_done_i,
  input  logic            wr_go_i,
  output logic            busy_o,
  output logic [RA-1:0]   fi_o,
  output logic [RA-1:0]   fj_o,
  output logic [RA-1:0]   fk_o,
  output logic            rj_o,
  output logic            rk_o,
  output logic            rd_go_o,
  output logic            wr_pend_o
);
  fu_stage_e       stage_q;
  logic [RA-1:0]   fi_q, fj_q, fk_q;
  logic [FU_W-1:0] qj_q, qk_q;
  logic            qj_v_q, qk_v_q, rj_q, rk_q;
  logic            hit1, hit2, hitj, hitk;

  // producer writing back in the issue cycle forwards at once
  assign hit1 = q1_pend_i && wb_en_i && (wb_tag_i == q1_tag_i);
  assign hit2 = q2_pend_i && wb_en_i && (wb_tag_i == q2_tag_i);
  assign hitj = qj_v_q && wb_en_i && (wb_tag_i == qj_q);
  assign hitk = qk_v_q && wb_en_i && (wb_tag_i == qk_q);

  assign busy_o    = (stage_q != ST_IDLE);
  assign rd_go_o   = (stage_q == ST_READ) && rj_q && rk_q;
  assign wr_pend_o = (stage_q == ST_WRITE);
  assign fi_o = fi_q;
  assign fj_o = fj_q;
  assign fk_o = fk_q;
  assign rj_o = rj_q;
  assign rk_o = rk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE;
      fi_q <= '0; fj_q <= '0; fk_q <= '0;
      qj_q <= '0; qk_q <= '0;
      qj_v_q <= 1'b0; qk_v_q <= 1'b0;
      rj_q <= 1'b0; rk_q <= 1'b0;
    end else if (iss_en_i) begin
      stage_q <= ST_READ;
      fi_q <= dst_i; fj_q <= src1_i; fk_q <= src2_i;
      qj_q <= q1_tag_i; qk_q <= q2_tag_i;
      qj_v_q <= q1_pend_i && !hit1;
      qk_v_q <= q2_pend_i && !hit2;
      rj_q <= !q1_pend_i || hit1;
      rk_q <= !q2_pend_i || hit2;
    end else begin
      unique case (stage_q)
        ST_READ: begin
          if (rd_go_o) begin
            stage_q <= ST_EXEC;
            rj_q <= 1'b0; rk_q <= 1'b0;
            qj_v_q <= 1'b0; qk_v_q <= 1'b0;
          end else begin
            if (hitj) begin rj_q <= 1'b1; qj_v_q <= 1'b0; end
            if (hitk) begin rk_q <= 1'b1; qk_v_q <= 1'b0; end
          end
        end
        ST_EXEC:  if (ex_done_i) stage_q <= ST_WRITE;
        ST_WRITE: if (wr_go_i) stage_q <= ST_IDLE;
        default:  ;
      endcase
    end
  end

  p_issue_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_en_i |-> stage_q == ST_IDLE);
  p_write_after_exec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go_i |-> stage_q == ST_WRITE);
  p_read_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_go_o |=> !rd_go_o);
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
  import sb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_FU-1:0] req_i,
  output logic [NUM_FU-1:0] gnt_o,
  output logic              any_o,
  output logic [FU_W-1:0]   idx_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (req_i[u] && !any_o) begin
        gnt_o[u] = 1'b1;
        idx_o    = FU_W'(u);
        any_o    = 1'b1;
      end
    end
  end

  p_one_writer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_requested_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard
  import sb_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int RA = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              iss_valid_i,
  input  logic [1:0]        iss_kind_i,
  input  logic [RA-1:0]     iss_dst_i,
  input  logic [RA-1:0]     iss_src1_i,
  input  logic [RA-1:0]     iss_src2_i,
  output logic              iss_grant_o,
  output logic [FU_W-1:0]   iss_fu_o,
  output logic [NUM_FU-1:0] rd_go_o,
  input  logic [NUM_FU-1:0] ex_done_i,
  output logic [NUM_FU-1:0] wr_go_o
);
  logic [NUM_FU-1:0] busy, fu_en, wr_pend, war_ok, rj, rk;
  logic [RA-1:0]     fi [NUM_FU];
  logic [RA-1:0]     fj [NUM_FU];
  logic [RA-1:0]     fk [NUM_FU];
  logic              a_pend, b_pend, d_pend, wb_any;
  logic [FU_W-1:0]   a_tag, b_tag, wb_idx;

  sb_issue_ctl u_issue (
    .valid_i    (iss_valid_i),
    .kind_i     (fu_kind_e'(iss_kind_i)),
    .busy_i     (busy),
    .dst_pend_i (d_pend),
    .grant_o    (iss_grant_o),
    .fu_o       (iss_fu_o),
    .fu_en_o    (fu_en)
  );

  sb_reg_status #(.NREGS(NREGS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (iss_grant_o),
    .set_idx_i (iss_dst_i),
    .set_tag_i (iss_fu_o),
    .clr_en_i  (wb_any),
    .clr_idx_i (fi[wb_idx]),
    .clr_tag_i (wb_idx),
    .rd_a_i    (iss_src1_i),
    .rd_b_i    (iss_src2_i),
    .rd_d_i    (iss_dst_i),
    .a_pend_o  (a_pend),
    .a_tag_o   (a_tag),
    .b_pend_o  (b_pend),
    .b_tag_o   (b_tag),
    .d_pend_o  (d_pend)
  );

  for (genvar u = 0; u < NUM_FU; u++) begin : g_fu
    sb_fu_entry #(.RA(RA)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .iss_en_i  (fu_en[u]),
      .dst_i     (iss_dst_i),
      .src1_i    (iss_src1_i),
      .src2_i    (iss_src2_i),
      .q1_pend_i (a_pend),
      .q1_tag_i  (a_tag),
      .q2_pend_i (b_pend),
      .q2_tag_i  (b_tag),
      .wb_en_i   (wb_any),
      .wb_tag_i  (wb_idx),
      .ex_done_i (ex_done_i[u]),
      .wr_go_i   (wr_go_o[u]),
      .busy_o    (busy[u]),
      .fi_o      (fi[u]),
      .fj_o      (fj[u]),
      .fk_o      (fk[u]),
      .rj_o      (rj[u]),
      .rk_o      (rk[u]),
      .rd_go_o   (rd_go_o[u]),
      .wr_pend_o (wr_pend[u])
    );
  end

  // WAR: hold write while another unit still has to read the old value
  always_comb begin
    for (int u = 0; u < NUM_FU; u++) begin
      war_ok[u] = 1'b1;
      for (int f = 0; f < NUM_FU; f++) begin
        if (f != u && busy[f] &&
            ((fj[f] == fi[u] && rj[f]) || (fk[f] == fi[u] && rk[f])))
          war_ok[u] = 1'b0;
      end
    end
  end

  sb_wb_arb u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (wr_pend & war_ok),
    .gnt_o  (wr_go_o),
    .any_o  (wb_any),
    .idx_o  (wb_idx)
  );

  for (genvar w = 0; w < NUM_FU; w++) begin : g_war_chk
    for (genvar f = 0; f < NUM_FU; f++) begin : g_rd
      if (f != w) begin : g_pair
        p_no_overwrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (wr_go_o[w] && rd_go_o[f]) |-> (fj[f] != fi[w] && fk[f] != fi[w]));
      end
    end
  end
endmodule

// File: tb/sim_fu_scoreboard.sv
module sim_fu_scoreboard;
  import sb_pkg::*;

  localparam int RA = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          iss_valid_i = 1'b0;
  logic [1:0]    iss_kind_i = '0;
  logic [RA-1:0] iss_dst_i = '0, iss_src1_i = '0, iss_src2_i = '0;
  logic          iss_grant_o;
  logic [2:0]    iss_fu_o;
  logic [4:0]    rd_go_o, wr_go_o;
  logic [4:0]    ex_done_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fu_scoreboard u0 (.*);

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic drv(input bit v, input int k, input int d, input int a, input int b);
    iss_valid_i = v;
    iss_kind_i  = 2'(k);
    iss_dst_i   = RA'(d);
    iss_src1_i  = RA'(a);
    iss_src2_i  = RA'(b);
    #1;
  endtask

  task automatic drain();
    drv(0, 0, 0, 0, 0);
    ex_done_i = '1;
    repeat (12) tick();
    ex_done_i = '0;
    #1;
  endtask

  task automatic t_reset_basic();
    chk(iss_grant_o, 0, "R1 idle grant");
    chk(rd_go_o, 0, "R1 idle read");
    chk(wr_go_o, 0, "R1 idle write");
    drv(1, 0, 1, 2, 3);
    chk(iss_grant_o, 1, "R1 first grant");
    chk(iss_fu_o, 0, "R2 int to unit 0");
    chk(rd_go_o, 0, "R6 no read at issue");
    tick(); drv(0, 0, 0, 0, 0); ex_done_i = 5'b00001; #1;
    chk(rd_go_o, 5'b00001, "R6 read after issue");
    tick(); ex_done_i = '0; #1;
    chk(rd_go_o, 0, "R6 single pulse");
    chk(wr_go_o, 0, "R7 done ignored in read");
    tick(); ex_done_i = 5'b00001; #1;
    chk(wr_go_o, 0, "R7 no write during done");
    tick(); ex_done_i = '0; #1;
    chk(wr_go_o, 5'b00001, "R7 write after done");
    tick(); drv(1, 0, 1, 2, 3);
    chk(iss_grant_o, 1, "R10 unit reusable");
    chk(iss_fu_o, 0, "R10 same unit");
    tick(); drain();
  endtask

  task automatic t_struct_mul();
    drv(1, 2, 4, 1, 2);
    chk(iss_fu_o, 2, "R2 first mul unit 2");
    chk(iss_grant_o, 1, "R2 first mul grant");
    tick(); drv(1, 2, 5, 1, 2);
    chk(iss_grant_o, 1, "R2 second mul grant");
    chk(iss_fu_o, 3, "R2 second mul unit 3");
    tick(); drv(1, 2, 6, 1, 2);
    chk(iss_grant_o, 0, "R2 both mul busy");
    tick();
    chk(iss_grant_o, 0, "R4 head held");
    ex_done_i = '1;
    tick();
    chk(wr_go_o, 5'b00100, "R9 unit 2 before unit 3");
    chk(iss_grant_o, 0, "R4 still held");
    tick();
    chk(iss_grant_o, 1, "R4 held head issues");
    chk(iss_fu_o, 2, "R2 freed unit 2 chosen");
    ex_done_i = '0;
    tick(); drain();
  endtask

  task automatic t_waw();
    drv(1, 1, 7, 1, 2);
    chk(iss_grant_o, 1, "R3 add grant");
    tick(); drv(1, 3, 7, 3, 4);
    chk(iss_grant_o, 0, "R3 waw blocks div");
    tick(); ex_done_i = 5'b00010; #1;
    chk(iss_grant_o, 0, "R3 waw still blocks");
    tick(); ex_done_i = '0; #1;
    chk(wr_go_o, 5'b00010, "R3 add writes");
    chk(iss_grant_o, 0, "R10 blocked in write cycle");
    tick();
    chk(iss_grant_o, 1, "R10 dest freed");
    chk(iss_fu_o, 4, "R2 div to unit 4");
    tick(); drain();
  endtask

  task automatic t_raw();
    drv(1, 3, 8, 1, 2);
    tick(); drv(1, 1, 9, 8, 3);
    chk(iss_grant_o, 1, "R5 consumer issues");
    chk(iss_fu_o, 1, "R5 consumer unit");
    tick(); drv(0, 0, 0, 0, 0); ex_done_i = 5'b10000; #1;
    chk(rd_go_o, 0, "R5 consumer waits");
    tick(); ex_done_i = '0; #1;
    chk(wr_go_o, 5'b10000, "R5 producer writes");
    chk(rd_go_o, 0, "R5 no read in producer write cycle");
    tick();
    chk(rd_go_o, 5'b00010, "R5 read after producer write");
    tick(); drain();
  endtask

  task automatic t_forward();
    drv(1, 2, 10, 1, 2);
    tick(); drv(0, 0, 0, 0, 0);
    tick(); ex_done_i = 5'b00100; #1;
    tick(); ex_done_i = '0; drv(1, 1, 11, 10, 5);
    chk(wr_go_o, 5'b00100, "R11 producer writes");
    chk(iss_grant_o, 1, "R11 consumer issues");
    tick(); drv(0, 0, 0, 0, 0);
    chk(rd_go_o, 5'b00010, "R11 forwarded read");
    tick(); drain();
  endtask

  task automatic t_war();
    drv(1, 3, 12, 1, 2);
    tick(); drv(1, 1, 13, 12, 14);
    chk(iss_grant_o, 1, "R8 reader issues");
    chk(rd_go_o, 5'b10000, "R8 div reads");
    tick(); drv(1, 0, 14, 1, 2);
    chk(iss_grant_o, 1, "R8 writer issues");
    tick(); drv(0, 0, 0, 0, 0);
    chk(rd_go_o, 5'b00001, "R8 writer reads alone");
    tick(); ex_done_i = 5'b00001; #1;
    tick(); ex_done_i = '0; #1;
    chk(wr_go_o, 0, "R8 write held");
    tick(); ex_done_i = 5'b10000; #1;
    chk(wr_go_o, 0, "R8 write still held");
    tick(); ex_done_i = '0; #1;
    chk(wr_go_o, 5'b10000, "R8 div writes");
    tick();
    chk(rd_go_o, 5'b00010, "R8 reader reads");
    chk(wr_go_o, 0, "R8 held during read");
    tick();
    chk(wr_go_o, 5'b00001, "R8 write after read");
    tick(); drain();
  endtask

  task automatic t_priority();
    drv(1, 0, 15, 1, 2);
    tick(); drv(1, 1, 16, 3, 4);
    chk(iss_grant_o, 1, "R9 add issues");
    tick(); drv(0, 0, 0, 0, 0);
    tick(); ex_done_i = 5'b00011; #1;
    tick(); ex_done_i = '0; #1;
    chk(wr_go_o, 5'b00001, "R9 unit 0 first");
    tick();
    chk(wr_go_o, 5'b00010, "R9 unit 1 next");
    tick(); drain();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();
    t_reset_basic();
    t_struct_mul();
    t_waw();
    t_raw();
    t_forward();
    t_war();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule